// File: doc/BRIEF.md
# Spawn-Join Thread Dispatch Controller

This block hands out virtual thread numbers to a set of parallel thread units for one spawn-join region. A serial master offers a spawn carrying a thread count `n`. Once the spawn is accepted, it goes out to every unit at once. Each unit runs its own unit index as its first virtual thread. After that, each unit claims a new thread number whenever it finishes one, through an atomic prefix-sum on a shared counter. A unit whose claimed number is `n` or more stops and counts as retired. When all units have retired, the controller emits a single join pulse, and the master continues its serial work.

There is no lockstep. Each unit runs at the pace of its own thread bodies, and the join is the only point where the units meet. The thread bodies lie outside the block. A unit is told to start a thread through `tcu_start`/`tcu_tid` and reports the end of that thread on `tcu_done`. The spawn side uses a valid/ready handshake. A spawn moves across only in a cycle where `spawn_valid` and `spawn_ready` are both high. `spawn_ready` stays low for the whole time a region is running, which rules out nested spawns. The master may hold or withdraw a request that has not yet been accepted, and that request has no effect.

Top module: `spj_dispatch`

## Requirements
- R1: `spawn_ready` is high exactly when no region is running. A spawn is taken on a cycle where `spawn_valid` and `spawn_ready` are both high, and that cycle captures `spawn_count` as `n`.
- R2: While a region is running, `spawn_valid` is not taken and has no effect: the count and the set of issued thread numbers do not change.
- R3: In the cycle after acceptance, every unit i with i < n shows `tcu_start[i]` high with `tcu_tid` slice i equal to i. That slice is bits i*CNT_W up to i*CNT_W+CNT_W-1.
- R4: After its first thread, a unit that raises `tcu_done` for one cycle takes its next number from a shared counter. That counter is loaded with NUM_TCU at spawn. If the number is valid, the unit shows `tcu_start` with it in the following cycle.
- R5: Units that finish in the same cycle receive distinct consecutive numbers, with the lower unit index getting the lower number. Across a region, every number from 0 to n-1 is issued exactly once.
- R6: A unit whose claimed number is n or more retires without a start. No start ever carries a number of n or more.
- R7: A unit whose index is n or more retires at spawn and never starts.
- R8: `join_pulse` is high for exactly one cycle, in the cycle after the last unit retires. `spawn_ready` is high again in that same cycle.
- R9: A spawn with n = 0 raises `join_pulse` in the second cycle after acceptance, and no unit starts.
- R10: `tcu_done` from a unit that is not running a thread is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| spawn_valid | input | 1 | Master offers a spawn |
| spawn_ready | output | 1 | Controller idle, spawn can be taken |
| spawn_count | input | CNT_W | Thread count n of the offered spawn |
| tcu_start | output | NUM_TCU | Per unit: begin thread in `tcu_tid` slice (one cycle) |
| tcu_tid | output | NUM_TCU*CNT_W | Per-unit virtual thread number, unit i in slice i |
| tcu_done | input | NUM_TCU | Per unit: current thread finished (one cycle) |
| join_pulse | output | 1 | One-cycle join at the end of the region |

## Verification
The prefix-sum fetch is the function that can hit several units in the same cycle. This happens when more than one unit finishes a thread at once, and those fetches may coincide with other units retiring past the end of the range. The bench provokes this by giving every thread body a latency of one cycle, so all units complete together again and again. It judges the result by checking that the numbers started together rise with the unit index, and that over the region no number repeats and none is missing. Irregular latencies then mix single and grouped fetches with retirements.

// File: rtl/spj_pkg.sv
package spj_pkg;
  typedef enum logic [1:0] {
    SL_IDLE = 2'd0,
    SL_RUN  = 2'd1,
    SL_RET  = 2'd2
  } slot_state_t;
endpackage

// File: rtl/spj_psum.sv
// Shared thread-number counter with a multi-requester prefix-sum.
module spj_psum #(
  parameter int NUM_TCU = 4,
  parameter int CW      = 11
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            load,
  input  logic [NUM_TCU-1:0]              req,
  output logic [NUM_TCU-1:0][CW-1:0]      ids
);
  logic [CW-1:0]                base_q;
  logic [NUM_TCU:0][CW-1:0]     pre;

  // Running sum: requester i sees base plus the requests below it.
  always_comb begin
    pre[0] = base_q;
    for (int i = 0; i < NUM_TCU; i++) begin
      pre[i+1] = pre[i] + CW'(req[i]);
    end
  end

  for (genvar g = 0; g < NUM_TCU; g++) begin : g_id
    assign ids[g] = pre[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    base_q <= '0;
    else if (load) base_q <= CW'(NUM_TCU);
    else           base_q <= pre[NUM_TCU];
  end

  // R4: after a spawn the next fetch starts at NUM_TCU
  a_r4_counter_reload: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (ids[0] == CW'(NUM_TCU)));

  // R5: the counter never moves backwards within a region
  a_r5_counter_monotone: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && $past(!load)) |-> (base_q >= $past(base_q)));
endmodule

// File: rtl/spj_slot.sv
// Per-unit dispatch state: first thread from the unit index, then fetched IDs.
module spj_slot
  import spj_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int CW    = 11,
  parameter int HW_ID = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             launch,
  input  logic [CNT_W-1:0] n,
  input  logic             done,
  input  logic [CW-1:0]    grant,
  output logic             req,
  output logic             start,
  output logic [CNT_W-1:0] tid,
  output logic             retired
);
  localparam logic [CW-1:0] HW_V = CW'(HW_ID);

  slot_state_t   st_q;
  logic [CW-1:0] n_ext;

  assign n_ext   = CW'(n);
  assign req     = (st_q == SL_RUN) && done;
  assign retired = (st_q == SL_RET);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SL_IDLE;
      start <= 1'b0;
      tid   <= '0;
    end else begin
      start <= 1'b0;
      if (launch) begin
        if (HW_V < n_ext) begin
          st_q  <= SL_RUN;
          start <= 1'b1;
          tid   <= HW_V[CNT_W-1:0];
        end else begin
          st_q  <= SL_RET;
        end
      end else if (req) begin
        if (grant < n_ext) begin
          start <= 1'b1;
          tid   <= grant[CNT_W-1:0];
        end else begin
          st_q  <= SL_RET;
        end
      end
    end
  end

  // R6: a start never carries a number past the range
  a_r6_start_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (CW'(tid) < n_ext));

  // R10: a retired unit stays silent whatever its done input does
  a_r10_retired_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SL_RET && !launch) |=> (!start && st_q == SL_RET));
endmodule

// File: rtl/spj_join.sv
// Region tracking and join generation.
module spj_join #(
  parameter int NUM_TCU = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               accept,
  input  logic [NUM_TCU-1:0] retired,
  output logic               active,
  output logic               join_p
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      join_p <= 1'b0;
    end else begin
      join_p <= 1'b0;
      if (accept) begin
        active <= 1'b1;
      end else if (active && (&retired)) begin
        active <= 1'b0;
        join_p <= 1'b1;
      end
    end
  end

  // R8: join lasts one cycle
  a_r8_join_single: assert property (@(posedge clk) disable iff (!rst_n)
    join_p |=> !join_p);

  // R8: join only follows a cycle in which every unit was retired
  a_r8_join_after_retire: assert property (@(posedge clk) disable iff (!rst_n)
    join_p |-> ($past(&retired) && !active));
endmodule

// File: rtl/spj_dispatch.sv
// Spawn-join dispatch controller top.
module spj_dispatch #(
  parameter int NUM_TCU = 4,
  parameter int CNT_W   = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       spawn_valid,
  output logic                       spawn_ready,
  input  logic [CNT_W-1:0]           spawn_count,
  output logic [NUM_TCU-1:0]         tcu_start,
  output logic [NUM_TCU*CNT_W-1:0]   tcu_tid,
  input  logic [NUM_TCU-1:0]         tcu_done,
  output logic                       join_pulse
);
  localparam int CW = CNT_W + $clog2(NUM_TCU) + 1;

  logic                          active;
  logic                          accept;
  logic [CNT_W-1:0]              n_q;
  logic [CNT_W-1:0]              n_eff;
  logic [NUM_TCU-1:0]            req;
  logic [NUM_TCU-1:0]            retired;
  logic [NUM_TCU-1:0][CW-1:0]    ids;
  logic [NUM_TCU-1:0][CNT_W-1:0] tid_a;

  assign spawn_ready = !active;
  assign accept      = spawn_valid && spawn_ready;
  assign n_eff       = accept ? spawn_count : n_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      n_q <= '0;
    else if (accept) n_q <= spawn_count;
  end

  spj_psum #(.NUM_TCU(NUM_TCU), .CW(CW)) u_psum (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (accept),
    .req   (req),
    .ids   (ids)
  );

  for (genvar g = 0; g < NUM_TCU; g++) begin : g_slot
    spj_slot #(.CNT_W(CNT_W), .CW(CW), .HW_ID(g)) u_slot (
      .clk     (clk),
      .rst_n   (rst_n),
      .launch  (accept),
      .n       (n_eff),
      .done    (tcu_done[g]),
      .grant   (ids[g]),
      .req     (req[g]),
      .start   (tcu_start[g]),
      .tid     (tid_a[g]),
      .retired (retired[g])
    );
    assign tcu_tid[g*CNT_W +: CNT_W] = tid_a[g];
  end

  spj_join #(.NUM_TCU(NUM_TCU)) u_join (
    .clk     (clk),
    .rst_n   (rst_n),
    .accept  (accept),
    .retired (retired),
    .active  (active),
    .join_p  (join_pulse)
  );

  // R2: the captured count holds for the whole region
  a_r2_count_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active)) |-> $stable(n_q));

  // R9: an empty spawn starts no unit
  a_r9_empty_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && spawn_count == '0) |=> (tcu_start == '0));
endmodule

// File: tb/spj_dispatch_tb_top.sv
module spj_dispatch_tb_top;
  localparam int P          = 4;
  localparam int CNT_W      = 8;
  localparam int CLK_PERIOD = 10;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               spawn_valid = 1'b0;
  logic               spawn_ready;
  logic [CNT_W-1:0]   spawn_count = '0;
  logic [P-1:0]       tcu_start;
  logic [P*CNT_W-1:0] tcu_tid;
  logic [P-1:0]       tcu_done;
  logic               join_pulse;
  logic [P-1:0]       model_done = '0;
  logic [P-1:0]       force_done = '0;

  assign tcu_done = model_done | force_done;

  always #(CLK_PERIOD/2) clk = ~clk;

  spj_dispatch #(.NUM_TCU(P), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .spawn_valid(spawn_valid), .spawn_ready(spawn_ready),
    .spawn_count(spawn_count), .tcu_start(tcu_start), .tcu_tid(tcu_tid),
    .tcu_done(tcu_done), .join_pulse(join_pulse)
  );

  int nchk = 0;
  int nfail = 0;
  int seen [0:255];
  int starts [P];
  int cnt [P];
  bit got_first [P];
  int join_cnt = 0;
  int cur_n = 0;
  int mode = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int lat(input int i, input int t);
    if (mode == 0) return 1;
    if (mode == 1) return ((t * 7 + i * 3) % 5) + 1;
    return i + 1 + (t % 2);
  endfunction

  // Thread-unit model and start monitor
  always @(negedge clk) begin
    if (rst_n) begin
      int last_t;
      last_t = -1;
      if (join_pulse) join_cnt++;
      for (int i = 0; i < P; i++) begin
        int t;
        t = int'(tcu_tid[i*CNT_W +: CNT_W]);
        if (tcu_start[i]) begin
          check(t < cur_n, "R6 start number in range", t, cur_n - 1);
          if (t < cur_n) begin
            check(seen[t] == 0, "R5 number issued once", seen[t] + 1, 1);
            seen[t]++;
          end
          if (!got_first[i]) begin
            check(t == i, "R3 first number is unit index", t, i);
            got_first[i] = 1'b1;
          end else begin
            check(model_done[i] == 1'b1, "R4 start follows done by one cycle", 0, 1);
            if (last_t >= 0)
              check(t == last_t + 1, "R5 same-cycle numbers rise with index", t, last_t + 1);
            last_t = t;
          end
          starts[i]++;
        end
        if (cnt[i] == 1) begin
          model_done[i] = 1'b1;
          cnt[i] = 0;
        end else begin
          model_done[i] = 1'b0;
          if (cnt[i] > 1) cnt[i]--;
        end
        if (tcu_start[i]) cnt[i] = lat(i, t);
      end
    end
  end

  task automatic clear_book(input int n, input int m);
    for (int k = 0; k < 256; k++) seen[k] = 0;
    for (int i = 0; i < P; i++) begin
      starts[i] = 0;
      got_first[i] = 1'b0;
    end
    join_cnt = 0;
    cur_n = n;
    mode = m;
  endtask

  // Full region: optional stray done on the top unit (R10) and busy spawn (R2)
  task automatic run_block(input int n, input int m, input bit stray, input bit intr);
    int waited;
    bit join_ready_ok;
    clear_book(n, m);
    @(negedge clk);
    check(spawn_ready == 1'b1, "R1 ready high when idle", spawn_ready, 1);
    spawn_valid = 1'b1;
    spawn_count = CNT_W'(n);
    @(negedge clk);
    spawn_valid = 1'b0;
    check(spawn_ready == 1'b0, "R1 ready low while running", spawn_ready, 0);
    if (stray) begin
      force_done[P-1] = 1'b1;
      @(negedge clk);
      force_done[P-1] = 1'b0;
    end
    if (intr) begin
      repeat (3) @(negedge clk);
      spawn_valid = 1'b1;
      spawn_count = CNT_W'(3);
      for (int k = 0; k < 3; k++) begin
        @(negedge clk);
        check(spawn_ready == 1'b0, "R2 busy spawn not taken", spawn_ready, 0);
      end
      spawn_valid = 1'b0;
    end
    waited = 0;
    join_ready_ok = 1'b0;
    while (join_cnt == 0 && waited < 5000) begin
      @(negedge clk);
      waited++;
      if (join_pulse) join_ready_ok = spawn_ready;
    end
    check(join_cnt == 1, "R8 join seen", join_cnt, 1);
    check(join_ready_ok, "R8 ready high in join cycle", join_ready_ok, 1);
    repeat (3) @(negedge clk);
    check(join_cnt == 1, "R8 join lasts one cycle", join_cnt, 1);
    begin
      int miss;
      miss = 0;
      for (int k = 0; k < n; k++) if (seen[k] != 1) miss++;
      check(miss == 0, "R5 every number issued exactly once", miss, 0);
    end
    for (int i = n; i < P; i++)
      check(starts[i] == 0, "R7 unit past n never starts", starts[i], 0);
  endtask

  task automatic t_reset;
    check(spawn_ready == 1'b1, "R1 reset ready", spawn_ready, 1);
    check(join_pulse == 1'b0, "R8 reset join low", join_pulse, 0);
    check(tcu_start == '0, "R3 reset no start", int'(tcu_start), 0);
  endtask

  task automatic t_zero;
    clear_book(0, 0);
    @(negedge clk);
    spawn_valid = 1'b1;
    spawn_count = '0;
    @(negedge clk);
    spawn_valid = 1'b0;
    check(join_pulse == 1'b0, "R9 no join first cycle", join_pulse, 0);
    @(negedge clk);
    check(join_pulse == 1'b1, "R9 join second cycle", join_pulse, 1);
    @(negedge clk);
    check(join_pulse == 1'b0, "R9 join dropped", join_pulse, 0);
    check(spawn_ready == 1'b1, "R9 idle again", spawn_ready, 1);
    for (int i = 0; i < P; i++)
      check(starts[i] == 0, "R9 no unit started", starts[i], 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    nchk++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    for (int i = 0; i < P; i++) cnt[i] = 0;
    clear_book(0, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    run_block(12, 0, 1'b0, 1'b0);  // R5 simultaneous fetches
    run_block(23, 1, 1'b0, 1'b0);  // R4 irregular latencies
    run_block(2, 2, 1'b1, 1'b0);   // R7, R10 stray done on retired unit
    t_zero();                      // R9
    run_block(20, 1, 1'b0, 1'b1);  // R2 busy spawn
    run_block(61, 2, 1'b0, 1'b0);  // R6 long region
    run_block(P, 0, 1'b0, 1'b0);   // R6 exact unit count
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule